// File: doc/BRIEF.md
# SPI Serial Flash Slave Responder

This block behaves as the slave end of a small serial flash memory on an SPI mode 0 link. A master lowers chip select, clocks bytes in on MOSI and collects replies on MISO. The first byte of each transaction is an opcode. Depending on the opcode, the block reads or programs an on-chip byte array, reports a write-enable latch, returns a fixed three-byte identification, or sets or clears the latch. Raising chip select ends the transaction, and the next byte is again read as an opcode.

SCK, MOSI and chip select are oversampled in the system clock domain. The master's SCK half period must be at least three system clock cycles. A byte shifter frames the bits into bytes. A command decoder walks through the opcode, address and data phases. It prepares each reply byte one byte slot ahead, so the reply's most significant bit is on MISO before the first rising edge of its slot. The array depth is a power-of-two parameter. The input `wr_permit` decides whether the write-enable opcode can take effect.

Top module: `spi_flash_responder`

## Requirements
- R1: Opcode 0x03 followed by three address bytes, most significant first, returns the byte stored at that address in the next byte slot, then successive bytes from incrementing addresses for as long as clocking continues.
- R2: Address bits above the array's width are discarded. While reading or programming, the address after DEPTH-1 is 0.
- R3: Opcode 0x9F returns 0x20, 0x40, 0x12 in the following byte slots, and the sequence starts again at 0x20 for as long as clocking continues.
- R4: Opcode 0x05 returns the status byte in every following byte slot of the transaction. The status byte is 0x02 when the write-enable latch is set and 0x00 when it is clear.
- R5: Opcode 0x06 sets the write-enable latch only while `wr_permit` is high. With `wr_permit` low, a clear latch stays clear.
- R6: Opcode 0x04 clears the write-enable latch.
- R7: With the latch set, opcode 0x0A followed by three address bytes stores each later MOSI byte at successive addresses, and MISO stays 0 throughout.
- R8: With the latch clear, opcode 0x0A changes no memory byte, and MISO stays 0 for the rest of the transaction.
- R9: An opcode byte of 0x00 does nothing, and the byte after it is decoded as an opcode.
- R10: Raising chip select abandons any command and resets bit framing, so the next transaction starts with an opcode and with identification at its first byte.
- R11: A transaction that accepted opcode 0x0A clears the write-enable latch when chip select rises.
- R12: Any other opcode makes the rest of its transaction ignored. Later bytes are not decoded, and MISO stays 0.
- R13: After reset, and whenever chip select is high, MISO is 0. After reset the latch is clear.
- R14: MOSI is sampled on SCK rising edges. MISO changes only after an SCK falling edge or while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from master |
| wr_permit | input | 1 | Allows opcode 0x06 to set the write-enable latch |
| miso | output | 1 | Serial data to master |

## Verification
A bad write-enable latch shows up in the next status read: the byte is 0x02 or 0x00 where the other was due. It also shows in a later read, which returns stale or changed data after a program that should have been refused or accepted. A slip in the bit counter or the phase state moves every later reply by one slot or by some bits, so the byte compare fails in the same transaction. A wrong address or identification index shows in the first data or identification byte after the opcode. Every MISO bit is also sampled before and after its rising edge, so a change away from a falling edge is caught in the bit where it happens.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_READ, ST_WRITE, ST_IDENT, ST_STATUS, ST_IGNORE
  } flash_state_e;

  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_PROG  = 8'h0A;
  localparam logic [7:0] OP_IDENT = 8'h9F;

  function automatic logic [7:0] ident_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h20;
      2'd1:    return 8'h40;
      default: return 8'h12;
    endcase
  endfunction

  function automatic logic [1:0] ident_next(input logic [1:0] idx);
    return (idx == 2'd2) ? 2'd0 : idx + 2'd1;
  endfunction

  function automatic logic [7:0] status_byte(input logic wel);
    return {6'b0, wel, 1'b0};
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int BITS = 8,
  localparam int CW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sck,
  input  logic            mosi,
  input  logic [BITS-1:0] reply,
  output logic            miso,
  output logic [BITS-1:0] rx_byte,
  output logic            byte_done
);
  logic            sck_q;
  logic            sck_rise, sck_fall;
  logic [CW-1:0]   bit_cnt_q;
  logic [BITS-1:0] shin_q, tx_q;

  assign sck_rise  = sck & ~sck_q & ~cs_n;
  assign sck_fall  = ~sck & sck_q & ~cs_n;
  assign byte_done = sck_rise && (bit_cnt_q == CW'(BITS - 1));
  assign rx_byte   = {shin_q[BITS-2:0], mosi};
  assign miso      = tx_q[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      bit_cnt_q <= '0;
      shin_q    <= '0;
      tx_q      <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        bit_cnt_q <= '0;
        tx_q      <= '0;
      end else begin
        if (sck_rise) begin
          shin_q    <= rx_byte;
          bit_cnt_q <= byte_done ? '0 : bit_cnt_q + 1'b1;
        end
        if (sck_fall) begin
          if (bit_cnt_q == '0) tx_q <= reply;
          else                 tx_q <= {tx_q[BITS-2:0], 1'b0};
        end
      end
    end
  end

  // R10
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (bit_cnt_q == '0));
  // R14
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(sck_fall) || $past(cs_n)));
  // R13
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !miso);

endmodule

// File: rtl/spi_flash_store.sv
module spi_flash_store #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_flash_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          byte_done,
  input  logic [7:0]    rx_byte,
  input  logic          wr_permit,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] mem_raddr,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic [7:0]    reply
);
  flash_state_e  state_q;
  logic [AW-1:0] addr_q, addr_loaded;
  logic [1:0]    addr_cnt_q, id_idx_q;
  logic          is_prog_q, prog_seen_q, wel_q;
  logic [7:0]    reply_q;
  logic          addr_last;

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  assign addr_loaded = AW'({addr_q, rx_byte});
  assign addr_last   = (state_q == ST_ADDR) && (addr_cnt_q == 2'd2);
  assign mem_raddr   = addr_last ? addr_loaded : addr_q;
  assign mem_waddr   = addr_q;
  assign mem_wdata   = rx_byte;
  assign mem_we      = byte_done && !cs_n && (state_q == ST_WRITE);
  assign reply       = reply_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      addr_cnt_q  <= '0;
      id_idx_q    <= '0;
      is_prog_q   <= 1'b0;
      prog_seen_q <= 1'b0;
      wel_q       <= 1'b0;
      reply_q     <= '0;
    end else if (cs_n) begin
      state_q     <= ST_IDLE;
      addr_cnt_q  <= '0;
      reply_q     <= '0;
      prog_seen_q <= 1'b0;
      if (prog_seen_q) wel_q <= 1'b0;
    end else if (byte_done) begin
      reply_q <= '0;
      case (state_q)
        ST_IDLE: begin
          case (rx_byte)
            OP_NOP: ;
            OP_READ: begin
              state_q    <= ST_ADDR;
              is_prog_q  <= 1'b0;
              addr_cnt_q <= '0;
            end
            OP_PROG: begin
              if (wel_q) begin
                state_q     <= ST_ADDR;
                is_prog_q   <= 1'b1;
                prog_seen_q <= 1'b1;
                addr_cnt_q  <= '0;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
            OP_IDENT: begin
              state_q  <= ST_IDENT;
              reply_q  <= ident_byte(2'd0);
              id_idx_q <= ident_next(2'd0);
            end
            OP_RDSR: begin
              state_q <= ST_STATUS;
              reply_q <= status_byte(wel_q);
            end
            OP_WREN: if (wr_permit) wel_q <= 1'b1;
            OP_WRDI: wel_q <= 1'b0;
            default: state_q <= ST_IGNORE;
          endcase
        end
        ST_ADDR: begin
          addr_q     <= addr_loaded;
          addr_cnt_q <= addr_cnt_q + 2'd1;
          if (addr_last) begin
            if (is_prog_q) begin
              state_q <= ST_WRITE;
            end else begin
              state_q <= ST_READ;
              reply_q <= rd_data;
              addr_q  <= addr_next(addr_loaded);
            end
          end
        end
        ST_READ: begin
          reply_q <= rd_data;
          addr_q  <= addr_next(addr_q);
        end
        ST_WRITE:  addr_q <= addr_next(addr_q);
        ST_IDENT: begin
          reply_q  <= ident_byte(id_idx_q);
          id_idx_q <= ident_next(id_idx_q);
        end
        ST_STATUS: reply_q <= status_byte(wel_q);
        default: ;
      endcase
    end
  end

  // R5
  wel_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(wr_permit));
  // R11
  prog_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && prog_seen_q) |=> !wel_q);
  // R10
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (state_q == ST_IDLE));
  // R12
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> (reply_q == '0));
  // R3
  ident_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_idx_q != 2'd3);
  // R8
  prog_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> prog_seen_q);

endmodule

// File: rtl/spi_flash_responder.sv
module spi_flash_responder #(
  parameter int DEPTH = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wr_permit,
  output logic miso
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    rx_byte, reply, rd_data, wdata;
  logic          byte_done, we;
  logic [AW-1:0] raddr, waddr;

  spi_byte_shifter #(.BITS(8)) shifter_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .reply(reply), .miso(miso), .rx_byte(rx_byte), .byte_done(byte_done)
  );

  spi_cmd_decoder #(.DEPTH(DEPTH), .AW(AW)) decoder_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_done(byte_done),
    .rx_byte(rx_byte), .wr_permit(wr_permit), .rd_data(rd_data),
    .mem_raddr(raddr), .mem_waddr(waddr), .mem_we(we),
    .mem_wdata(wdata), .reply(reply)
  );

  spi_flash_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rd_data)
  );

endmodule

// File: tb/spi_flash_responder_tb_top.sv
module spi_flash_responder_tb_top;
  logic clk = 1'b0;
  logic rst_n, cs_n, sck, mosi, wr_permit;
  logic miso;

  localparam int HALF = 4;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] got_q[$];
  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_flash_responder #(.DEPTH(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wr_permit(wr_permit), .miso(miso)
  );

  // monitor: pops expected and captured bytes and compares them
  always @(negedge clk) begin
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      exp_t       e;
      logic [7:0] g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      tests++;
      if (g !== e.v) begin
        fails++;
        $display("FAIL %s got %02h expected %02h", e.tag, g, e.v);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_off();
    tick(HALF);
    cs_n = 1'b1;
    tick(HALF);
  endtask

  // driver: one byte slot; pushes expectation when chk is set
  task automatic xfer(input logic [7:0] o, input logic [7:0] e,
                      input bit chk, input string tag);
    logic [7:0] cap;
    logic pre;
    bit   unstable;
    unstable = 1'b0;
    if (chk) begin
      exp_t x;
      x.v = e;
      x.tag = tag;
      exp_q.push_back(x);
    end
    for (int i = 7; i >= 0; i--) begin
      mosi = o[i];
      tick(HALF);
      pre = miso;
      cap[i] = miso;
      sck = 1'b1;
      tick(HALF);
      if (miso !== pre) unstable = 1'b1;
      sck = 1'b0;
    end
    tests++;
    if (unstable) begin
      fails++;
      $display("FAIL R14 miso moved during high phase got 1 expected 0");
    end
    if (chk) got_q.push_back(cap);
  endtask

  task automatic one_cmd(input logic [7:0] op);
    cs_on();
    xfer(op, 8'h00, 1'b0, "");
    cs_off();
  endtask

  task automatic read_status(input logic [7:0] e, input string tag);
    cs_on();
    xfer(8'h05, 8'h00, 1'b1, tag);
    xfer(8'h00, e, 1'b1, tag);
    cs_off();
  endtask

  task automatic send_addr(input logic [23:0] a, input bit chk, input string tag);
    xfer(a[23:16], 8'h00, chk, tag);
    xfer(a[15:8],  8'h00, chk, tag);
    xfer(a[7:0],   8'h00, chk, tag);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wr_permit = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(2);

    tests++;
    if (miso !== 1'b0) begin
      fails++;
      $display("FAIL R13 miso after reset got %b expected 0", miso);
    end
    read_status(8'h00, "R13 latch clear after reset");

    // R5: permit low blocks set
    one_cmd(8'h06);
    read_status(8'h00, "R5 wren refused");

    // R5 / R4: permit high, status repeats
    wr_permit = 1'b1;
    one_cmd(8'h06);
    cs_on();
    xfer(8'h05, 8'h00, 1'b1, "R4 opcode slot");
    xfer(8'h00, 8'h02, 1'b1, "R5 wren accepted");
    xfer(8'h00, 8'h02, 1'b1, "R4 status repeat");
    xfer(8'h00, 8'h02, 1'b1, "R4 status repeat");
    cs_off();

    // R7: program three bytes at 0x10
    cs_on();
    xfer(8'h0A, 8'h00, 1'b1, "R7 miso zero");
    send_addr(24'h000010, 1'b1, "R7 miso zero");
    xfer(8'hA1, 8'h00, 1'b1, "R7 miso zero");
    xfer(8'hA2, 8'h00, 1'b1, "R7 miso zero");
    xfer(8'hA3, 8'h00, 1'b1, "R7 miso zero");
    cs_off();
    read_status(8'h00, "R11 latch cleared by program");

    // R1: read back
    cs_on();
    xfer(8'h03, 8'h00, 1'b1, "R1 opcode slot");
    send_addr(24'h000010, 1'b0, "");
    xfer(8'h00, 8'hA1, 1'b1, "R1 first byte");
    xfer(8'h00, 8'hA2, 1'b1, "R1 second byte");
    xfer(8'h00, 8'hA3, 1'b1, "R1 third byte");
    cs_off();

    // R2: wrap at end of array
    one_cmd(8'h06);
    cs_on();
    xfer(8'h0A, 8'h00, 1'b0, "");
    send_addr(24'h0000FF, 1'b0, "");
    xfer(8'h5A, 8'h00, 1'b0, "");
    xfer(8'h6B, 8'h00, 1'b0, "");
    cs_off();
    cs_on();
    xfer(8'h03, 8'h00, 1'b0, "");
    send_addr(24'h0000FF, 1'b0, "");
    xfer(8'h00, 8'h5A, 1'b1, "R2 last address");
    xfer(8'h00, 8'h6B, 1'b1, "R2 wrapped to zero");
    cs_off();
    cs_on();
    xfer(8'h03, 8'h00, 1'b0, "");
    send_addr(24'h1234FF, 1'b0, "");
    xfer(8'h00, 8'h5A, 1'b1, "R2 upper bits dropped");
    cs_off();

    // R8: program refused without latch
    cs_on();
    xfer(8'h0A, 8'h00, 1'b1, "R8 miso zero");
    send_addr(24'h000010, 1'b1, "R8 miso zero");
    xfer(8'hFF, 8'h00, 1'b1, "R8 miso zero");
    cs_off();
    cs_on();
    xfer(8'h03, 8'h00, 1'b0, "");
    send_addr(24'h000010, 1'b0, "");
    xfer(8'h00, 8'hA1, 1'b1, "R8 memory unchanged");
    cs_off();

    // R3: identification wraps
    cs_on();
    xfer(8'h9F, 8'h00, 1'b1, "R3 opcode slot");
    xfer(8'h00, 8'h20, 1'b1, "R3 byte 0");
    xfer(8'h00, 8'h40, 1'b1, "R3 byte 1");
    xfer(8'h00, 8'h12, 1'b1, "R3 byte 2");
    xfer(8'h00, 8'h20, 1'b1, "R3 wrap byte 0");
    xfer(8'h00, 8'h40, 1'b1, "R3 wrap byte 1");
    cs_off();

    // R6: disable clears latch
    one_cmd(8'h06);
    read_status(8'h02, "R6 latch set first");
    one_cmd(8'h04);
    read_status(8'h00, "R6 latch cleared");

    // R9: no-op then real opcode
    cs_on();
    xfer(8'h00, 8'h00, 1'b1, "R9 nop slot");
    xfer(8'h00, 8'h00, 1'b1, "R9 nop slot");
    xfer(8'h9F, 8'h00, 1'b1, "R9 opcode after nop");
    xfer(8'h00, 8'h20, 1'b1, "R9 ident after nop");
    cs_off();

    // R12: unknown opcode swallows the transaction
    cs_on();
    xfer(8'hFF, 8'h00, 1'b1, "R12 miso zero");
    xfer(8'h06, 8'h00, 1'b1, "R12 miso zero");
    xfer(8'h9F, 8'h00, 1'b1, "R12 not decoded");
    xfer(8'h00, 8'h00, 1'b1, "R12 not decoded");
    cs_off();
    read_status(8'h00, "R12 wren not decoded");

    // R10: aborts
    cs_on();
    xfer(8'h03, 8'h00, 1'b0, "");
    xfer(8'h00, 8'h00, 1'b0, "");
    cs_off();
    cs_on();
    xfer(8'h9F, 8'h00, 1'b1, "R10 opcode after abort");
    xfer(8'h00, 8'h20, 1'b1, "R10 ident after aborted read");
    xfer(8'h00, 8'h40, 1'b1, "R10 ident second");
    cs_off();
    cs_on();
    xfer(8'h9F, 8'h00, 1'b0, "");
    xfer(8'h00, 8'h20, 1'b1, "R10 ident restarts");
    cs_off();
    cs_on();
    mosi = 1'b1;
    sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    sck = 1'b1; tick(HALF); sck = 1'b0;
    cs_off();
    cs_on();
    xfer(8'h9F, 8'h00, 1'b1, "R10 partial byte dropped");
    xfer(8'h00, 8'h20, 1'b1, "R10 framing reset");
    cs_off();

    tick(10);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule